// File: doc/BRIEF.md
# Power-Fail Chip-Enable Write-Protect Gate

This block sits between a memory controller's single active-low chip-enable and two banks of battery-backed static RAM. While the supply is good, a bank-select bit steers each access to one of the two bank enables. When an external comparator reports that the supply has left tolerance, the gate stops any new access from reaching the memories. An access that is already under way may finish, but only within a bounded window. After that window both bank enables are held inactive, whatever the chip-enable input does.

The block also drives an active-low system reset. This reset goes low as soon as the supply is lost. It is held low for a programmable number of cycles after the supply returns, and the bank gate opens in the same cycle that the reset releases. The power-good flag is asynchronous to the system clock and is brought in through a two-flop synchroniser.

Top module: `pfw_ce_gate`

## Requirements
- R1: `ce_n`, `ce1_n` and `ce2_n` are active low, and the bank outputs are registered, so a chip-enable change shows up one clock later. A high `ce_n` makes both outputs high on the next cycle. While `rst` is asserted, both outputs are high and `sys_rst_n` is low.
- R2: While the gate is open, a `bank_sel` value of 0 routes the access to `ce1_n` and a value of 1 routes it to `ce2_n`. The other output stays high.
- R3: `bank_sel` is captured in the cycle where `ce_n` goes from high to low. Changing it later in the same access has no effect on the outputs.
- R4: `ce1_n` and `ce2_n` are never low at the same time.
- R5: If the supply is lost while no access is under way, both outputs stay high until the gate reopens.
- R6: If an access is under way when the supply is lost, its output keeps following `ce_n` until `ce_n` rises. From then on both outputs stay high, even if `ce_n` goes low again.
- R7: An access that is left to finish after a power loss keeps its output low for at most TIMEOUT_CYCLES cycles after the power loss reaches the gate. Its output goes high four cycles plus TIMEOUT_CYCLES cycles after `pwr_ok` falls.
- R8: After power returns, `sys_rst_n` stays low for HOLD_CYCLES cycles once the synchronised flag is seen. It rises three cycles plus HOLD_CYCLES cycles after `pwr_ok` rises. An access that begins in the cycle the reset releases is passed to the outputs.
- R9: `pwr_ok` passes through two synchronising flops before it acts. `sys_rst_n` falls three cycles after `pwr_ok` falls, and it only rises after the synchronised flag has been high.
- R10: An access whose falling edge of `ce_n` comes while `sys_rst_n` is low is never passed to either output. This includes an access that is still in progress when the gate reopens.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_ok | input | 1 | Asynchronous power-good flag from the supply comparator |
| ce_n | input | 1 | Active-low chip-enable from the memory controller |
| bank_sel | input | 1 | Bank select: 0 selects bank 1, 1 selects bank 2 |
| ce1_n | output | 1 | Conditioned active-low enable for bank 1 |
| ce2_n | output | 1 | Conditioned active-low enable for bank 2 |
| sys_rst_n | output | 1 | Active-low system reset |

## Verification
The bench builds the gate with TIMEOUT_CYCLES of 20 and HOLD_CYCLES of 8, instead of the 15000 and 256 used at 100 MHz. With these values both the forced lock after an over-long drain and the release of the reset after power returns happen a few dozen cycles after the supply edge. The bench can therefore count the exact cycle of each event, not just wait for it. The short values also leave room for a drain that ends early, for an access held across power-up, and for the bank-steering table, all in one short run.

// File: rtl/pfw_pkg.sv
package pfw_pkg;
  typedef enum logic [1:0] {
    GS_OFF   = 2'd0,
    GS_HOLD  = 2'd1,
    GS_RUN   = 2'd2,
    GS_DRAIN = 2'd3
  } gate_state_e;
endpackage

// File: rtl/pfw_sync.sv
module pfw_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '0;
    else     chain_q <= {chain_q[STAGES-2:0], din};
  end

  assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/pfw_guard.sv
module pfw_guard
  import pfw_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 15000,
  parameter int HOLD_CYCLES    = 256
) (
  input  logic clk,
  input  logic rst,
  input  logic pwr_ok_s,
  input  logic ce_n,
  input  logic acc_live,
  output logic start_ok,
  output logic hold_ok,
  output logic sys_rst_n
);
  localparam int LIMIT = (TIMEOUT_CYCLES > HOLD_CYCLES) ? TIMEOUT_CYCLES : HOLD_CYCLES;
  localparam int CW    = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] TO_LAST   = CW'(TIMEOUT_CYCLES - 1);
  localparam logic [CW-1:0] HOLD_LAST = CW'(HOLD_CYCLES - 1);

  gate_state_e state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic rst_n_q;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q + CW'(1);
    case (state_q)
      GS_OFF: begin
        cnt_d = '0;
        if (pwr_ok_s) state_d = GS_HOLD;
      end
      GS_HOLD: begin
        if (!pwr_ok_s) begin
          state_d = GS_OFF;
          cnt_d   = '0;
        end else if (cnt_q == HOLD_LAST) begin
          state_d = GS_RUN;
          cnt_d   = '0;
        end
      end
      GS_RUN: begin
        cnt_d = '0;
        if (!pwr_ok_s) state_d = (acc_live && !ce_n) ? GS_DRAIN : GS_OFF;
      end
      GS_DRAIN: begin
        if (ce_n || cnt_q == TO_LAST) begin
          state_d = GS_OFF;
          cnt_d   = '0;
        end
      end
      default: begin
        state_d = GS_OFF;
        cnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= GS_OFF;
      cnt_q   <= '0;
      rst_n_q <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      rst_n_q <= (state_d == GS_RUN);
    end
  end

  assign start_ok  = (state_q == GS_RUN) && pwr_ok_s;
  assign hold_ok   = (state_q == GS_RUN) || (state_q == GS_DRAIN);
  assign sys_rst_n = rst_n_q;
endmodule

// File: rtl/pfw_bank_decode.sv
module pfw_bank_decode #(
  parameter int BANKS = 2,
  localparam int BW   = (BANKS > 1) ? $clog2(BANKS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ce_n,
  input  logic [BW-1:0]    bank_sel,
  input  logic             start_ok,
  input  logic             hold_ok,
  output logic             acc_live,
  output logic [BANKS-1:0] bank_ce_n
);
  logic          ce_d_q;
  logic [BW-1:0] bank_q;
  logic [BW-1:0] bank_eff;
  logic          acc_q, acc_d, fall;

  assign fall     = !ce_n && ce_d_q;
  assign bank_eff = fall ? bank_sel : bank_q;
  assign acc_d    = !ce_n && (fall ? start_ok : (acc_q && hold_ok));

  always_ff @(posedge clk) begin
    if (rst) begin
      ce_d_q <= 1'b1;
      bank_q <= '0;
      acc_q  <= 1'b0;
    end else begin
      ce_d_q <= ce_n;
      acc_q  <= acc_d;
      if (fall) bank_q <= bank_sel;
    end
  end

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    always_ff @(posedge clk) begin
      if (rst) bank_ce_n[b] <= 1'b1;
      else     bank_ce_n[b] <= !(acc_d && (bank_eff == BW'(b)));
    end
  end

  assign acc_live = acc_q;
endmodule

// File: rtl/pfw_ce_gate.sv
module pfw_ce_gate #(
  parameter int CLK_MHZ        = 100,
  parameter int TIMEOUT_CYCLES = 150 * CLK_MHZ,
  parameter int HOLD_CYCLES    = 256,
  parameter int SYNC_STAGES    = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pwr_ok,
  input  logic ce_n,
  input  logic bank_sel,
  output logic ce1_n,
  output logic ce2_n,
  output logic sys_rst_n
);
  logic       pwr_ok_s;
  logic       start_ok, hold_ok, acc_live;
  logic [1:0] bank_ce_n;

  pfw_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst(rst), .din(pwr_ok), .dout(pwr_ok_s)
  );

  pfw_guard #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES), .HOLD_CYCLES(HOLD_CYCLES)) guard_i (
    .clk(clk), .rst(rst), .pwr_ok_s(pwr_ok_s), .ce_n(ce_n), .acc_live(acc_live),
    .start_ok(start_ok), .hold_ok(hold_ok), .sys_rst_n(sys_rst_n)
  );

  pfw_bank_decode #(.BANKS(2)) dec_i (
    .clk(clk), .rst(rst), .ce_n(ce_n), .bank_sel(bank_sel),
    .start_ok(start_ok), .hold_ok(hold_ok), .acc_live(acc_live), .bank_ce_n(bank_ce_n)
  );

  assign ce1_n = bank_ce_n[0];
  assign ce2_n = bank_ce_n[1];
endmodule

// File: rtl/pfw_ce_gate_chk.sv
module pfw_ce_gate_chk #(
  parameter int TIMEOUT_CYCLES = 15000
) (
  input logic clk,
  input logic rst,
  input logic ce_n,
  input logic ce1_n,
  input logic ce2_n,
  input logic sys_rst_n,
  input logic pwr_ok_s
);
  int unsigned drain_run;

  always_ff @(posedge clk) begin
    if (rst) drain_run <= 0;
    else if (!sys_rst_n && (!ce1_n || !ce2_n)) drain_run <= drain_run + 1;
    else drain_run <= 0;
  end

  // R4
  bank_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    ce1_n || ce2_n);

  // R1
  idle_blocks_chk: assert property (@(posedge clk) disable iff (rst)
    ce_n |=> (ce1_n && ce2_n));

  // R10
  late_start_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(ce_n) && !sys_rst_n) |=> (ce1_n && ce2_n));

  // R9
  release_after_sync_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sys_rst_n) |-> $past(pwr_ok_s));

  // R7
  drain_bound_chk: assert property (@(posedge clk) disable iff (rst)
    drain_run <= TIMEOUT_CYCLES + 1);
endmodule

bind pfw_ce_gate pfw_ce_gate_chk #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) chk_i (
  .clk(clk), .rst(rst), .ce_n(ce_n), .ce1_n(ce1_n), .ce2_n(ce2_n),
  .sys_rst_n(sys_rst_n), .pwr_ok_s(pwr_ok_s)
);

// File: tb/pfw_ce_gate_tb.sv
module pfw_ce_gate_tb_top;
  localparam int T = 20;
  localparam int H = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pwr_ok = 1'b0;
  logic ce_n = 1'b1;
  logic bank_sel = 1'b0;
  logic ce1_n, ce2_n, sys_rst_n;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pfw_ce_gate #(.TIMEOUT_CYCLES(T), .HOLD_CYCLES(H)) dut_i (
    .clk(clk), .rst(rst), .pwr_ok(pwr_ok), .ce_n(ce_n), .bank_sel(bank_sel),
    .ce1_n(ce1_n), .ce2_n(ce2_n), .sys_rst_n(sys_rst_n)
  );

  // {ce_n, bank_sel, expected ce1_n, expected ce2_n}
  localparam logic [3:0] VEC [9] = '{
    4'b1011, 4'b0001, 4'b0101, 4'b1111, 4'b0110,
    4'b0010, 4'b1011, 4'b0001, 4'b1111
  };

  task automatic chk_eq(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  // which: 0 = sys_rst_n, 1 = ce1_n ; counts edges until it equals lvl
  task automatic count_until(input int which, input logic lvl, input int maxn, output int n);
    n = maxn + 1;
    for (int i = 1; i <= maxn; i++) begin
      cyc();
      if ((which == 0 ? sys_rst_n : ce1_n) == lvl) begin
        n = i;
        break;
      end
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int n;
    cyc(3);
    // R1 reset state
    chk_eq("R1 ce1_n in reset", ce1_n, 1);
    chk_eq("R1 ce2_n in reset", ce2_n, 1);
    chk_eq("R1 sys_rst_n in reset", sys_rst_n, 0);
    rst = 1'b0;
    cyc(2);

    // R10: access begun while reset active, held across release
    ce_n = 1'b0;
    bank_sel = 1'b0;
    pwr_ok = 1'b1;
    count_until(0, 1'b1, 40, n);
    chk_eq("R8 reset release cycle", n, 3 + H);
    for (int i = 0; i < 3; i++) begin
      cyc();
      chk_eq("R10 old access blocked ce1_n", ce1_n, 1);
    end
    ce_n = 1'b1;
    cyc();

    // R2 R3 steering table
    foreach (VEC[i]) begin
      ce_n = VEC[i][3];
      bank_sel = VEC[i][2];
      cyc();
      chk_eq("R2/R3 ce1_n table", ce1_n, VEC[i][1]);
      chk_eq("R2/R3 ce2_n table", ce2_n, VEC[i][0]);
    end

    // R5 R9: idle power loss
    pwr_ok = 1'b0;
    count_until(0, 1'b0, 10, n);
    chk_eq("R9 reset assert cycle", n, 3);
    ce_n = 1'b0;
    bank_sel = 1'b0;
    cyc(2);
    chk_eq("R5 ce1_n after idle loss", ce1_n, 1);
    chk_eq("R5 ce2_n after idle loss", ce2_n, 1);
    ce_n = 1'b1;
    cyc();

    // R8: gate opens with reset release
    pwr_ok = 1'b1;
    count_until(0, 1'b1, 40, n);
    chk_eq("R8 reset release cycle again", n, 3 + H);
    ce_n = 1'b0;
    cyc();
    chk_eq("R8 access at release passes", ce1_n, 0);
    ce_n = 1'b1;
    cyc();

    // R6: drain ends early, then lock
    bank_sel = 1'b1;
    ce_n = 1'b0;
    cyc(2);
    chk_eq("R6 ce2_n before loss", ce2_n, 0);
    pwr_ok = 1'b0;
    cyc(8);
    chk_eq("R6 ce2_n during drain", ce2_n, 0);
    chk_eq("R6 sys_rst_n during drain", sys_rst_n, 0);
    ce_n = 1'b1;
    cyc();
    chk_eq("R6 ce2_n after access end", ce2_n, 1);
    ce_n = 1'b0;
    cyc(3);
    chk_eq("R6 ce1_n locked", ce1_n, 1);
    chk_eq("R6 ce2_n locked", ce2_n, 1);
    ce_n = 1'b1;
    pwr_ok = 1'b1;
    count_until(0, 1'b1, 40, n);
    cyc();

    // R7: drain cut by timeout
    bank_sel = 1'b0;
    ce_n = 1'b0;
    cyc(2);
    chk_eq("R7 ce1_n before loss", ce1_n, 0);
    pwr_ok = 1'b0;
    count_until(1, 1'b1, 60, n);
    chk_eq("R7 timeout lock cycle", n, 4 + T);
    chk_eq("R4/R7 ce2_n after timeout", ce2_n, 1);
    cyc(2);
    chk_eq("R7 ce1_n stays locked", ce1_n, 1);
    ce_n = 1'b1;
    pwr_ok = 1'b1;
    count_until(0, 1'b1, 40, n);

    // R2 recovery after timeout
    bank_sel = 1'b1;
    ce_n = 1'b0;
    cyc();
    chk_eq("R2 ce2_n after recovery", ce2_n, 0);
    chk_eq("R2 ce1_n after recovery", ce1_n, 1);
    ce_n = 1'b1;
    cyc();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule